// File: doc/BRIEF.md
# Four-Bank DRAM Command Timing Gate

This block sits on the controller side of a four-bank double-data-rate SDRAM. Every clock a scheduler presents one candidate command with a bank number, a burst-length code and an auto-precharge flag. The gate keeps a model of each bank (open row or idle) and a set of countdown timers. From them it reports, for the presented bank, which of the eight command types could legally go out in this cycle. The scheduler uses the flag for its own command to decide whether to issue it.

When the scheduler raises `issue_i`, the command is taken as sent to the memory. The gate then updates its bank model and timers whether or not the command was legal. If an illegal command is forced out, `viol_o` pulses high in that same cycle. All delays are parameters counted in clock cycles. The defaults match the fastest speed grade. A write burst's data is taken to end BL/2 clocks after the WRITE, because data moves on both clock edges.

Top module: `bank_timing_gate`

## Requirements
- R1: After a synchronous reset (`rst_n` low at a clock edge), all banks are idle (`bank_open_o` = 0) and every timer is satisfied. For any bank, `allow_vec_o` then equals 8'hF3: NOP, ACTIVE, PRECHARGE, PRECHARGE-ALL, REFRESH and MODE-SET are allowed, and READ and WRITE are refused.
- R2: Command codes on `cmd_i`: 0 NOP, 1 ACTIVE, 2 READ, 3 WRITE, 4 PRECHARGE, 5 PRECHARGE-ALL, 6 AUTO-REFRESH, 7 MODE-SET (MRS/EMRS). Bit k of `allow_vec_o` is the verdict for code k on bank `bank_i`, `allow_o` equals `allow_vec_o[cmd_i]`, and NOP is always allowed.
- R3: ACTIVE is allowed only to an idle bank. It must come at least TRC (15) cycles after the previous ACTIVE to the same bank, at least TRP (5) cycles after that bank was precharged, and at least TRRD (3) cycles after an ACTIVE to any bank. An issued ACTIVE opens the bank.
- R4: READ and WRITE are allowed only to an open bank. A READ must come at least TRCDRD (5) cycles after that bank's ACTIVE, and a WRITE at least TRCDWR (3) cycles after it.
- R5: Any two column commands (READ or WRITE, any banks) are at least TCCD (1) cycle apart.
- R6: Burst code `bl_i`: 1 gives BL2, 2 gives BL4, 3 gives BL8, and 0 is treated as BL2. A write ends BL/2 cycles after issue. PRECHARGE to an open bank needs at least TRAS (10) cycles after its ACTIVE and BL/2+TWR (3) cycles after its last WRITE.
- R7: A READ to any bank is refused until BL/2+TCDLR (3) cycles after the last WRITE, so a READ never cuts into a write burst.
- R8: A WRITE with `ap_i`=1 closes its bank, and the next ACTIVE to that bank needs BL/2+TDAL (8) cycles. A READ with `ap_i`=1 closes its bank, and the next ACTIVE needs max(remaining PRECHARGE wait, BL/2)+TRP cycles. The other ACTIVE limits still apply.
- R9: PRECHARGE to an idle bank is always allowed and changes no timer. PRECHARGE-ALL is allowed when every open bank meets its PRECHARGE timing, and it closes all banks, each starting its TRP wait.
- R10: AUTO-REFRESH and MODE-SET are allowed only when all banks are idle and meet their ACTIVE timing. After an issued AUTO-REFRESH, ACTIVE, AUTO-REFRESH and MODE-SET wait TRFC (17) cycles.
- R11: After an issued MODE-SET, every command except NOP is refused for TMRD (2) cycles.
- R12: `viol_o` is high in a cycle exactly when `issue_i` is high and `allow_o` is low. An issued command updates the bank model even when it is illegal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_i | input | 3 | Candidate command code |
| bank_i | input | 2 | Bank the command targets |
| bl_i | input | 2 | Burst length code |
| ap_i | input | 1 | Auto-precharge with READ/WRITE |
| issue_i | input | 1 | Command is sent this cycle |
| allow_vec_o | output | 8 | Legal verdict per command code for `bank_i` |
| allow_o | output | 1 | Verdict for the presented command |
| viol_o | output | 1 | Illegal command issued this cycle |
| bank_open_o | output | 4 | Open flag per bank |

## Verification
First, each bank is swept separately after an ACTIVE, probing READ, WRITE and ACTIVE cycle by cycle. This tells the read and write activation delays apart and separates the per-bank spacing from the cross-bank spacing. Every burst code is then run through write-to-precharge, write-to-read and both auto-precharge cases, so that an error in the BL/2 arithmetic or in the max of competing limits moves the first allowed cycle. Further probes cover idle-bank precharge, precharge-all, refresh and mode-set. A long pseudo-random command stream, with some illegal commands forced out, compares the full eight-bit verdict every cycle against a model kept as absolute deadlines.

// File: rtl/bank_gate_pkg.sv
package bank_gate_pkg;

  parameter int CNT_W = 8;
  typedef logic [CNT_W-1:0] cnt_t;

  typedef enum logic [2:0] {
    CMD_NOP  = 3'd0,
    CMD_ACT  = 3'd1,
    CMD_RD   = 3'd2,
    CMD_WR   = 3'd3,
    CMD_PRE  = 3'd4,
    CMD_PREA = 3'd5,
    CMD_REF  = 3'd6,
    CMD_MRS  = 3'd7
  } cmd_e;

  localparam int NCMD = 8;

  // one step of a countdown that rests at zero
  function automatic cnt_t cnt_dec(input cnt_t c);
    return (c == '0) ? '0 : c - cnt_t'(1);
  endfunction

  function automatic cnt_t cnt_max(input cnt_t a, input cnt_t b);
    return (a > b) ? a : b;
  endfunction

  // make the command wait req cycles from now, keeping any longer wait
  function automatic cnt_t cnt_load(input cnt_t c, input cnt_t req);
    cnt_t r;
    r = (req == '0) ? '0 : req - cnt_t'(1);
    return cnt_max(cnt_dec(c), r);
  endfunction

  // clocks a burst occupies: data on both edges
  function automatic cnt_t burst_half(input logic [1:0] bl);
    case (bl)
      2'd2:    return cnt_t'(2);
      2'd3:    return cnt_t'(4);
      default: return cnt_t'(1);
    endcase
  endfunction

endpackage

// File: rtl/bank_state.sv
module bank_state
  import bank_gate_pkg::*;
#(
  parameter int TRC    = 15,
  parameter int TRAS   = 10,
  parameter int TRP    = 5,
  parameter int TRCDRD = 5,
  parameter int TRCDWR = 3,
  parameter int TWR    = 3,
  parameter int TDAL   = 8,
  parameter int TRFC   = 17
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hit_i,
  input  logic       issue_i,
  input  logic [2:0] cmd_i,
  input  logic       ap_i,
  input  cnt_t       half_i,
  output logic       open_o,
  output logic       act_rdy_o,
  output logic       rd_rdy_o,
  output logic       wr_rdy_o,
  output logic       pre_rdy_o
);

  cmd_e cmd;
  assign cmd = cmd_e'(cmd_i);

  logic open_q;
  cnt_t rd_c, wr_c, pre_c, act_c;

  // named events for the assertions
  logic act_evt, rd_evt, wr_evt, pre_evt, ref_evt, ap_close;
  cnt_t rd_ap_wait;

  assign act_evt    = hit_i && (cmd == CMD_ACT);
  assign rd_evt     = hit_i && (cmd == CMD_RD);
  assign wr_evt     = hit_i && (cmd == CMD_WR);
  assign pre_evt    = open_q && ((hit_i && (cmd == CMD_PRE)) ||
                                 (issue_i && (cmd == CMD_PREA)));
  assign ref_evt    = issue_i && (cmd == CMD_REF);
  assign ap_close   = (rd_evt || wr_evt) && ap_i;
  assign rd_ap_wait = cnt_max(pre_c, half_i) + cnt_t'(TRP);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      rd_c   <= '0;
      wr_c   <= '0;
      pre_c  <= '0;
      act_c  <= '0;
    end else begin
      rd_c <= act_evt ? cnt_load(rd_c, cnt_t'(TRCDRD)) : cnt_dec(rd_c);
      wr_c <= act_evt ? cnt_load(wr_c, cnt_t'(TRCDWR)) : cnt_dec(wr_c);

      if (act_evt)     pre_c <= cnt_load(pre_c, cnt_t'(TRAS));
      else if (wr_evt) pre_c <= cnt_load(pre_c, half_i + cnt_t'(TWR));
      else             pre_c <= cnt_dec(pre_c);

      if (act_evt)                act_c <= cnt_load(act_c, cnt_t'(TRC));
      else if (pre_evt)           act_c <= cnt_load(act_c, cnt_t'(TRP));
      else if (ref_evt)           act_c <= cnt_load(act_c, cnt_t'(TRFC));
      else if (wr_evt && ap_i)    act_c <= cnt_load(act_c, half_i + cnt_t'(TDAL));
      else if (rd_evt && ap_i)    act_c <= cnt_load(act_c, rd_ap_wait);
      else                        act_c <= cnt_dec(act_c);

      if (act_evt)                    open_q <= 1'b1;
      else if (pre_evt || ap_close)   open_q <= 1'b0;
    end
  end

  assign open_o    = open_q;
  assign act_rdy_o = (act_c == '0);
  assign rd_rdy_o  = (rd_c == '0);
  assign wr_rdy_o  = (wr_c == '0);
  assign pre_rdy_o = (pre_c == '0);

  AST_ACT_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
    act_evt |=> open_o); // R3
  AST_RCD_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ((TRCDRD > 1) && act_evt) |=> !rd_rdy_o); // R4
  AST_AP_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    ap_close |=> !open_o); // R8
  AST_ACT_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    (act_rdy_o && !(act_evt || pre_evt || ref_evt || ap_close)) |=> act_rdy_o); // R3

endmodule

// File: rtl/shared_timers.sv
module shared_timers
  import bank_gate_pkg::*;
#(
  parameter int TRRD  = 3,
  parameter int TCCD  = 1,
  parameter int TCDLR = 3,
  parameter int TMRD  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       issue_i,
  input  logic [2:0] cmd_i,
  input  cnt_t       half_i,
  output logic       rrd_rdy_o,
  output logic       ccd_rdy_o,
  output logic       wtr_rdy_o,
  output logic       mrd_rdy_o,
  output logic       wr_burst_o
);

  cmd_e cmd;
  assign cmd = cmd_e'(cmd_i);

  logic act_evt, col_evt, wr_evt, mrs_evt;
  cnt_t rrd_c, ccd_c, wtr_c, mrd_c;

  assign act_evt = issue_i && (cmd == CMD_ACT);
  assign wr_evt  = issue_i && (cmd == CMD_WR);
  assign col_evt = issue_i && ((cmd == CMD_RD) || (cmd == CMD_WR));
  assign mrs_evt = issue_i && (cmd == CMD_MRS);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rrd_c <= '0;
      ccd_c <= '0;
      wtr_c <= '0;
      mrd_c <= '0;
    end else begin
      rrd_c <= act_evt ? cnt_load(rrd_c, cnt_t'(TRRD)) : cnt_dec(rrd_c);
      ccd_c <= col_evt ? cnt_load(ccd_c, cnt_t'(TCCD)) : cnt_dec(ccd_c);
      wtr_c <= wr_evt  ? cnt_load(wtr_c, half_i + cnt_t'(TCDLR)) : cnt_dec(wtr_c);
      mrd_c <= mrs_evt ? cnt_load(mrd_c, cnt_t'(TMRD)) : cnt_dec(mrd_c);
    end
  end

  assign rrd_rdy_o  = (rrd_c == '0);
  assign ccd_rdy_o  = (ccd_c == '0);
  assign wtr_rdy_o  = (wtr_c == '0);
  assign mrd_rdy_o  = (mrd_c == '0);
  // data still on the bus while more than the turnaround remains
  assign wr_burst_o = (wtr_c >= cnt_t'(TCDLR));

  AST_MRD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ((TMRD > 1) && mrs_evt) |=> !mrd_rdy_o); // R11
  AST_CCD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ((TCCD > 1) && col_evt) |=> !ccd_rdy_o); // R5

endmodule

// File: rtl/bank_timing_gate.sv
module bank_timing_gate
  import bank_gate_pkg::*;
#(
  parameter int NBANK  = 4,
  parameter int TRC    = 15,
  parameter int TRAS   = 10,
  parameter int TRP    = 5,
  parameter int TRRD   = 3,
  parameter int TRFC   = 17,
  parameter int TRCDRD = 5,
  parameter int TRCDWR = 3,
  parameter int TWR    = 3,
  parameter int TCDLR  = 3,
  parameter int TDAL   = 8,
  parameter int TCCD   = 1,
  parameter int TMRD   = 2,
  localparam int BA_W  = (NBANK > 1) ? $clog2(NBANK) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       cmd_i,
  input  logic [BA_W-1:0]  bank_i,
  input  logic [1:0]       bl_i,
  input  logic             ap_i,
  input  logic             issue_i,
  output logic [NCMD-1:0]  allow_vec_o,
  output logic             allow_o,
  output logic             viol_o,
  output logic [NBANK-1:0] bank_open_o
);

  cnt_t half;
  assign half = burst_half(bl_i);

  logic [NBANK-1:0] hit, open_v, act_r, rd_r, wr_r, pre_r;
  logic rrd_rdy, ccd_rdy, wtr_rdy, mrd_rdy, wr_burst;

  for (genvar g = 0; g < NBANK; g++) begin : g_bank
    assign hit[g] = issue_i && (bank_i == BA_W'(g));
    bank_state #(
      .TRC(TRC), .TRAS(TRAS), .TRP(TRP), .TRCDRD(TRCDRD),
      .TRCDWR(TRCDWR), .TWR(TWR), .TDAL(TDAL), .TRFC(TRFC)
    ) u_bank (
      .clk(clk), .rst_n(rst_n), .hit_i(hit[g]), .issue_i(issue_i),
      .cmd_i(cmd_i), .ap_i(ap_i), .half_i(half),
      .open_o(open_v[g]), .act_rdy_o(act_r[g]), .rd_rdy_o(rd_r[g]),
      .wr_rdy_o(wr_r[g]), .pre_rdy_o(pre_r[g])
    );
  end

  shared_timers #(
    .TRRD(TRRD), .TCCD(TCCD), .TCDLR(TCDLR), .TMRD(TMRD)
  ) u_shared (
    .clk(clk), .rst_n(rst_n), .issue_i(issue_i), .cmd_i(cmd_i),
    .half_i(half), .rrd_rdy_o(rrd_rdy), .ccd_rdy_o(ccd_rdy),
    .wtr_rdy_o(wtr_rdy), .mrd_rdy_o(mrd_rdy), .wr_burst_o(wr_burst)
  );

  logic all_quiet, prea_ok, cur_open;
  assign cur_open  = open_v[bank_i];
  assign all_quiet = (open_v == '0) && (&act_r);
  assign prea_ok   = &(~open_v | pre_r);

  always_comb begin
    allow_vec_o           = '0;
    allow_vec_o[CMD_NOP]  = 1'b1;
    allow_vec_o[CMD_ACT]  = !cur_open && act_r[bank_i] && rrd_rdy;
    allow_vec_o[CMD_RD]   = cur_open && rd_r[bank_i] && ccd_rdy && wtr_rdy;
    allow_vec_o[CMD_WR]   = cur_open && wr_r[bank_i] && ccd_rdy;
    allow_vec_o[CMD_PRE]  = !cur_open || pre_r[bank_i];
    allow_vec_o[CMD_PREA] = prea_ok;
    allow_vec_o[CMD_REF]  = all_quiet;
    allow_vec_o[CMD_MRS]  = all_quiet;
    if (!mrd_rdy) allow_vec_o[NCMD-1:1] = '0;
  end

  assign allow_o     = allow_vec_o[cmd_i];
  assign viol_o      = issue_i && !allow_o;
  assign bank_open_o = open_v;

  AST_MRD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ((TMRD > 1) && issue_i && (cmd_i == CMD_MRS)) |=> (allow_vec_o[NCMD-1:1] == '0)); // R11
  AST_WR_NO_RD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_burst |-> !allow_vec_o[CMD_RD]); // R7
  AST_REF_ALL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    allow_vec_o[CMD_REF] |-> (bank_open_o == '0)); // R10
  AST_NOP_ALWAYS: assert property (@(posedge clk) disable iff (!rst_n)
    allow_vec_o[CMD_NOP]); // R2

endmodule

// File: tb/bank_timing_gate_tb.sv
`timescale 1ns/1ps
module bank_timing_gate_tb;

  localparam int TRC = 15, TRAS = 10, TRP = 5, TRRD = 3, TRFC = 17;
  localparam int TRCDRD = 5, TRCDWR = 3, TWR = 3, TCDLR = 3, TDAL = 8;
  localparam int TCCD = 1, TMRD = 2;
  localparam int C_NOP = 0, C_ACT = 1, C_RD = 2, C_WR = 3;
  localparam int C_PRE = 4, C_PREA = 5, C_REF = 6, C_MRS = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] cmd_i = '0;
  logic [1:0] bank_i = '0, bl_i = 2'd1;
  logic ap_i = 1'b0, issue_i = 1'b0;
  logic [7:0] allow_vec_o;
  logic allow_o, viol_o;
  logic [3:0] bank_open_o;

  always #2 clk = ~clk;

  bank_timing_gate u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_i(cmd_i), .bank_i(bank_i), .bl_i(bl_i),
    .ap_i(ap_i), .issue_i(issue_i), .allow_vec_o(allow_vec_o),
    .allow_o(allow_o), .viol_o(viol_o), .bank_open_o(bank_open_o)
  );

  int n_tests = 0, n_fail = 0, cyc = 0;
  logic [7:0] cap_vec;
  logic cap_viol, cap_allow;
  logic [3:0] cap_open;

  // model kept as absolute earliest-allowed cycles
  bit open_m[4];
  int rd_t[4], wr_t[4], pre_t[4], act_t[4];
  int rrd_t, ccd_t, wtr_t, mrd_t;

  task automatic chk(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic int hb(input logic [1:0] bl);
    return (bl == 2'd3) ? 4 : (bl == 2'd2) ? 2 : 1;
  endfunction

  function automatic string tag_of(input int k);
    case (k)
      C_ACT:          return "R3";
      C_RD, C_WR:     return "R4";
      C_PRE, C_PREA:  return "R9";
      C_REF:          return "R10";
      C_MRS:          return "R11";
      default:        return "R2";
    endcase
  endfunction

  function automatic bit m_allow(input int c, input int b);
    bit ok, all_idle, prea;
    all_idle = 1'b1;
    prea = 1'b1;
    for (int i = 0; i < 4; i++) begin
      if (open_m[i] || cyc < act_t[i]) all_idle = 1'b0;
      if (open_m[i] && cyc < pre_t[i]) prea = 1'b0;
    end
    case (c)
      C_ACT:  ok = !open_m[b] && cyc >= act_t[b] && cyc >= rrd_t;
      C_RD:   ok = open_m[b] && cyc >= rd_t[b] && cyc >= ccd_t && cyc >= wtr_t;
      C_WR:   ok = open_m[b] && cyc >= wr_t[b] && cyc >= ccd_t;
      C_PRE:  ok = !open_m[b] || cyc >= pre_t[b];
      C_PREA: ok = prea;
      C_REF, C_MRS: ok = all_idle;
      default: ok = 1'b1;
    endcase
    if (c != C_NOP && cyc < mrd_t) ok = 1'b0;
    return ok;
  endfunction

  task automatic m_apply(input int c, input int b, input logic [1:0] bl, input bit ap);
    int h;
    h = hb(bl);
    case (c)
      C_ACT: begin
        open_m[b] = 1'b1;
        rd_t[b]  = mx(rd_t[b], cyc + TRCDRD);
        wr_t[b]  = mx(wr_t[b], cyc + TRCDWR);
        pre_t[b] = mx(pre_t[b], cyc + TRAS);
        act_t[b] = mx(act_t[b], cyc + TRC);
        rrd_t    = mx(rrd_t, cyc + TRRD);
      end
      C_RD: begin
        ccd_t = mx(ccd_t, cyc + TCCD);
        if (ap) begin
          act_t[b] = mx(act_t[b], mx(pre_t[b], cyc + h) + TRP);
          open_m[b] = 1'b0;
        end
      end
      C_WR: begin
        ccd_t    = mx(ccd_t, cyc + TCCD);
        wtr_t    = mx(wtr_t, cyc + h + TCDLR);
        pre_t[b] = mx(pre_t[b], cyc + h + TWR);
        if (ap) begin
          act_t[b] = mx(act_t[b], cyc + h + TDAL);
          open_m[b] = 1'b0;
        end
      end
      C_PRE: if (open_m[b]) begin
        open_m[b] = 1'b0;
        act_t[b] = mx(act_t[b], cyc + TRP);
      end
      C_PREA: for (int i = 0; i < 4; i++) if (open_m[i]) begin
        open_m[i] = 1'b0;
        act_t[i] = mx(act_t[i], cyc + TRP);
      end
      C_REF: for (int i = 0; i < 4; i++) act_t[i] = mx(act_t[i], cyc + TRFC);
      C_MRS: mrd_t = mx(mrd_t, cyc + TMRD);
      default: ;
    endcase
  endtask

  task automatic step(input int c, input int b, input logic [1:0] bl, input bit ap, input bit iss);
    logic [3:0] exp_open;
    @(negedge clk);
    cmd_i = 3'(c); bank_i = 2'(b); bl_i = bl; ap_i = ap; issue_i = iss;
    #1;
    cap_vec = allow_vec_o; cap_viol = viol_o; cap_allow = allow_o; cap_open = bank_open_o;
    for (int k = 0; k < 8; k++) chk(tag_of(k), int'(cap_vec[k]), int'(m_allow(k, b)));
    chk("R2 allow_o", int'(cap_allow), int'(cap_vec[c]));
    chk("R12 viol", int'(cap_viol), int'(iss && !m_allow(c, b)));
    for (int i = 0; i < 4; i++) exp_open[i] = open_m[i];
    chk("R3 open", int'(cap_open), int'(exp_open));
    if (iss) m_apply(c, b, bl, ap);
    cyc++;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; issue_i = 1'b0; cmd_i = '0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) begin
      open_m[i] = 1'b0; rd_t[i] = 0; wr_t[i] = 0; pre_t[i] = 0; act_t[i] = 0;
    end
    rrd_t = 0; ccd_t = 0; wtr_t = 0; mrd_t = 0; cyc = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(C_NOP, 0, 2'd1, 1'b0, 1'b0);
  endtask

  initial begin
    #(4 * 200000);
    n_fail++;
    $display("FAIL watchdog expired R12 actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  logic [15:0] lf = 16'hACE1;
  task automatic lf_next();
    lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
  endtask

  initial begin
    // R1 reset state
    do_reset();
    for (int b = 0; b < 4; b++) begin
      step(C_NOP, b, 2'd1, 1'b0, 1'b0);
      chk("R1 vec", int'(cap_vec), 8'hF3);
      chk("R1 open", int'(cap_open), 0);
    end

    // R4 activate-to-column per bank, R3 same and other bank
    for (int b = 0; b < 4; b++) begin
      do_reset();
      step(C_ACT, b, 2'd1, 1'b0, 1'b1);
      for (int k = 1; k <= 7; k++) begin
        step(C_RD, b, 2'd1, 1'b0, 1'b0);
        chk("R4 act->rd", int'(cap_vec[C_RD]), int'(k >= TRCDRD));
        chk("R4 act->wr", int'(cap_vec[C_WR]), int'(k >= TRCDWR));
        chk("R3 act open bank", int'(cap_vec[C_ACT]), 0);
      end
      do_reset();
      step(C_ACT, b, 2'd1, 1'b0, 1'b1);
      for (int k = 1; k <= 5; k++) begin
        step(C_ACT, (b + 1) % 4, 2'd1, 1'b0, 1'b0);
        chk("R3 rrd", int'(cap_vec[C_ACT]), int'(k >= TRRD));
      end
    end

    // R5 column spacing
    do_reset();
    step(C_ACT, 0, 2'd1, 1'b0, 1'b1);
    idle(TRCDRD - 1);
    step(C_RD, 0, 2'd1, 1'b0, 1'b1);
    step(C_RD, 0, 2'd1, 1'b0, 1'b0);
    chk("R5 ccd", int'(cap_vec[C_RD]), int'(1 >= TCCD));

    // R6 write-to-precharge, R7 write-to-read, all burst codes
    for (int bl = 0; bl < 4; bl++) begin
      do_reset();
      step(C_ACT, 2, 2'(bl), 1'b0, 1'b1);
      idle(TRCDWR - 1);
      step(C_WR, 2, 2'(bl), 1'b0, 1'b1);
      for (int k = 1; k <= 12; k++) begin
        step(C_PRE, 2, 2'(bl), 1'b0, 1'b0);
        chk("R6 wr->pre", int'(cap_vec[C_PRE]), int'(k >= mx(TRAS - TRCDWR, hb(2'(bl)) + TWR)));
        chk("R7 wr->rd", int'(cap_vec[C_RD]), int'(k >= mx(TRCDRD - TRCDWR, hb(2'(bl)) + TCDLR)));
      end
    end

    // R8 auto-precharge on write and read
    for (int bl = 1; bl < 4; bl++) begin
      do_reset();
      step(C_ACT, 1, 2'(bl), 1'b0, 1'b1);
      idle(TRCDWR - 1);
      step(C_WR, 1, 2'(bl), 1'b1, 1'b1);
      for (int k = 1; k <= 16; k++) begin
        step(C_ACT, 1, 2'(bl), 1'b0, 1'b0);
        chk("R8 wr-ap open", int'(cap_open[1]), 0);
        chk("R8 wr-ap act", int'(cap_vec[C_ACT]), int'(k >= mx(hb(2'(bl)) + TDAL, TRC - TRCDWR)));
      end
      do_reset();
      step(C_ACT, 1, 2'(bl), 1'b0, 1'b1);
      idle(TRCDRD - 1);
      step(C_RD, 1, 2'(bl), 1'b1, 1'b1);
      for (int k = 1; k <= 14; k++) begin
        step(C_ACT, 1, 2'(bl), 1'b0, 1'b0);
        chk("R8 rd-ap act", int'(cap_vec[C_ACT]),
            int'(k >= mx(mx(TRAS - TRCDRD, hb(2'(bl))) + TRP, TRC - TRCDRD)));
      end
    end

    // R9 precharge to idle bank, precharge-all
    do_reset();
    step(C_PRE, 1, 2'd1, 1'b0, 1'b1);
    step(C_ACT, 1, 2'd1, 1'b0, 1'b0);
    chk("R9 pre idle no effect", int'(cap_vec[C_ACT]), 1);
    chk("R9 pre idle open", int'(cap_open), 0);
    do_reset();
    step(C_ACT, 0, 2'd1, 1'b0, 1'b1);
    idle(TRRD - 1);
    step(C_ACT, 1, 2'd1, 1'b0, 1'b1);
    for (int k = 1; k <= TRAS + 2; k++) begin
      step(C_PREA, 3, 2'd1, 1'b0, 1'b0);
      chk("R9 prea", int'(cap_vec[C_PREA]), int'(k >= TRAS));
    end
    step(C_PREA, 3, 2'd1, 1'b0, 1'b1);
    step(C_ACT, 0, 2'd1, 1'b0, 1'b0);
    chk("R9 prea closes", int'(cap_open), 0);

    // R10 refresh and mode-set gating
    do_reset();
    step(C_ACT, 3, 2'd1, 1'b0, 1'b1);
    step(C_REF, 0, 2'd1, 1'b0, 1'b0);
    chk("R10 ref open bank", int'(cap_vec[C_REF]), 0);
    chk("R10 mrs open bank", int'(cap_vec[C_MRS]), 0);
    do_reset();
    step(C_REF, 0, 2'd1, 1'b0, 1'b1);
    for (int k = 1; k <= TRFC + 2; k++) begin
      step(C_ACT, 0, 2'd1, 1'b0, 1'b0);
      chk("R10 rfc act", int'(cap_vec[C_ACT]), int'(k >= TRFC));
      chk("R10 rfc ref", int'(cap_vec[C_REF]), int'(k >= TRFC));
    end

    // R11 mode-set quiet window
    do_reset();
    step(C_MRS, 0, 2'd1, 1'b0, 1'b1);
    for (int k = 1; k <= 4; k++) begin
      step(C_NOP, 2, 2'd1, 1'b0, 1'b0);
      chk("R11 mrd", int'(cap_vec), (k >= TMRD) ? 8'hF3 : 8'h01);
    end

    // R12 forced illegal command
    do_reset();
    step(C_RD, 0, 2'd1, 1'b0, 1'b1);
    chk("R12 forced rd viol", int'(cap_viol), 1);
    step(C_ACT, 0, 2'd1, 1'b0, 1'b1);
    chk("R12 legal act viol", int'(cap_viol), 0);

    // pseudo-random stream, full verdict compared every cycle
    do_reset();
    for (int i = 0; i < 6000; i++) begin
      int c, b;
      bit frc;
      lf_next(); lf_next(); lf_next();
      c = int'(lf[2:0]);
      b = int'(lf[4:3]);
      frc = (lf[12:9] == 4'd0);
      step(c, b, lf[6:5], lf[7], m_allow(c, b) || frc);
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule